// File: doc/BRIEF.md
# DMA Channel Enable and Frame Overflow Register

This block is the status and enable register of one DMA channel. It holds the channel enable bit, a frame counter for chained-block operation and a sticky overflow flag. Software reaches it through a byte-wide write port and a combinational readback byte. The transfer engine drives it with strobes for completed frames and finished transfers, and with a level that shows a transfer is in progress.

The enable bit is guarded. A write changes it only when the guard bit of that same write is 0. When a transfer finishes, the enable bit clears by itself. If software clears the enable bit while a transfer is running, the block raises a one-cycle halt request.

In chained-block mode every completed frame advances a wrapping counter. When the counter wraps, the overflow flag is set. Software clears the flag by writing 1 to it. While the flag and the interrupt enable are both 1, an interrupt request is raised.

Top module: `dma_chan_ctl`

## Requirements
- R1: A write (`wr_en`=1) loads `wr_data[1]` into the enable bit only when `wr_data[0]` is 0 in the same write. When `wr_data[0]` is 1, or when there is no write, the enable bit keeps its value.
- R2: The readback byte `rd_data` has the enable bit at bit 1, a constant 1 at bit 0 (the guard bit is not stored), and 0 at bits 3:2 and 7:5, whatever value was written there.
- R3: A `xfer_end` strobe clears the enable bit at the next clock edge. It also wins over a guarded write of 1 in the same cycle.
- R4: `halt_pulse` is high for exactly the one cycle after an edge at which a guarded write of 0 to the enable bit was taken while the enable bit was 1 and `xfer_busy` was 1. In every other case it stays low.
- R5: In chained-block mode (`mode_chain`=1), each `frame_done` strobe advances a 4-bit counter. A strobe taken while the counter is 15 returns it to 0 and sets the overflow flag. Starting from reset, the 16th frame sets the flag.
- R6: In single-block mode (`mode_chain`=0), `frame_done` is ignored and the counter holds its value. Bit 4 of `rd_data` reads 0 and `irq` is 0.
- R7: Writing 1 to bit 4 clears the overflow flag. Writing 0 to bit 4 leaves it unchanged. This clear does not depend on the guard bit.
- R8: When the flag is set and cleared in the same cycle, it ends up set.
- R9: `irq` equals the overflow flag, as seen at `rd_data[4]`, ANDed with `ovf_irq_en`.
- R10: After reset the enable bit, the counter and the overflow flag are 0, `halt_pulse` is 0 and `rd_data` reads 8'h01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register readback byte |
| mode_chain | input | 1 | 1 = chained-block mode, 0 = single-block mode |
| frame_done | input | 1 | One-cycle strobe per completed frame |
| xfer_end | input | 1 | One-cycle strobe when the transfer end condition is met |
| xfer_busy | input | 1 | High while a transfer is in progress |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| chan_en | output | 1 | Channel enable bit |
| halt_pulse | output | 1 | One-cycle halt request |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest situation to reach from the ports is a frame that wraps the counter in the same cycle as a software write of 1 to bit 4. The counter is not visible, so the stimulus has to count the frames exactly and place the clearing write on the 16th frame of a round. The bench tracks the count itself. It also interleaves single-block stretches, where frames must not advance the counter, and then shows that the next overflow arrives exactly 16 chained frames later. The guard rule is swept over all 256 write values from both starting enable states.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned BIT_GUARD = 0;
  localparam int unsigned BIT_EN    = 1;
  localparam int unsigned BIT_OVF   = 4;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_CHAIN  = 1'b1
  } xfer_mode_e;

  typedef struct packed {
    logic take_en;
    logic en_val;
    logic clr_ovf;
  } reg_wr_s;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dma_enable_guard.sv
module dma_enable_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic take_en,
  input  logic en_val,
  input  logic xfer_end,
  input  logic xfer_busy,
  output logic en_q,
  output logic halt_q
);
  logic en_d;
  logic halt_d;
  logic en_ce;

  always_comb begin
    en_ce = take_en | xfer_end;
    en_d  = en_q;
    if (xfer_end)     en_d = 1'b0;
    else if (take_en) en_d = en_val;
    halt_d = take_en & ~en_val & en_q & xfer_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_d;
  end
endmodule

// File: rtl/dma_frame_tally.sv
module dma_frame_tally #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_chain,
  input  logic frame_done,
  input  logic clr_ovf,
  output logic ovf_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;
  logic             wrap;
  logic             ovf_d;
  logic             ovf_ce;

  always_comb begin
    cnt_ce = mode_chain & frame_done;
    wrap   = cnt_ce & (cnt_q == CNT_MAX);
    cnt_d  = wrap ? '0 : cnt_q + CNT_ONE;
    ovf_ce = wrap | clr_ovf;
    ovf_d  = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf_q <= 1'b0;
    else if (ovf_ce) ovf_q <= ovf_d;
  end
endmodule

// File: rtl/dma_status_view.sv
module dma_status_view
  import dma_chan_pkg::*;
(
  input  logic             en,
  input  logic             ovf,
  input  logic             mode_chain,
  output logic [REG_W-1:0] rd_data
);
  genvar gi;
  generate
    for (gi = 0; gi < REG_W; gi++) begin : g_bit
      if (gi == BIT_GUARD) begin : g_guard
        assign rd_data[gi] = 1'b1;
      end else if (gi == BIT_EN) begin : g_en
        assign rd_data[gi] = en;
      end else if (gi == BIT_OVF) begin : g_ovf
        assign rd_data[gi] = ovf & mode_chain;
      end else begin : g_zero
        assign rd_data[gi] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             mode_chain,
  input  logic             frame_done,
  input  logic             xfer_end,
  input  logic             xfer_busy,
  input  logic             ovf_irq_en,
  output logic             chan_en,
  output logic             halt_pulse,
  output logic             irq
);
  logic    rst_n_sync;
  logic    ovf_q;
  reg_wr_s wr_dec;

  dma_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  always_comb begin
    wr_dec.take_en = wr_en & ~wr_data[BIT_GUARD];
    wr_dec.en_val  = wr_data[BIT_EN];
    wr_dec.clr_ovf = wr_en & wr_data[BIT_OVF];
  end

  dma_enable_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .take_en   (wr_dec.take_en),
    .en_val    (wr_dec.en_val),
    .xfer_end  (xfer_end),
    .xfer_busy (xfer_busy),
    .en_q      (chan_en),
    .halt_q    (halt_pulse)
  );

  dma_frame_tally #(.CNT_W(CNT_W)) u_tally (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .mode_chain (mode_chain),
    .frame_done (frame_done),
    .clr_ovf    (wr_dec.clr_ovf),
    .ovf_q      (ovf_q)
  );

  dma_status_view u_view (
    .en         (chan_en),
    .ovf        (ovf_q),
    .mode_chain (mode_chain),
    .rd_data    (rd_data)
  );

  assign irq = ovf_q & ovf_irq_en & mode_chain;
endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       mode_chain,
  input logic       xfer_end,
  input logic       xfer_busy,
  input logic       ovf_irq_en,
  input logic       chan_en,
  input logic       halt_pulse,
  input logic       irq
);
  a_r1_guard_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0] && !xfer_end) |=> (chan_en == $past(chan_en)));

  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] == 1'b1) && (rd_data[3:2] == 2'b00) && (rd_data[7:5] == 3'b000)
    && (rd_data[1] == chan_en));

  a_r3_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> !chan_en);

  a_r4_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    halt_pulse |-> $past(wr_en && !wr_data[0] && !wr_data[1] && xfer_busy && chan_en));

  a_r4_halt_single: assert property (@(posedge clk) disable iff (!rst_n)
    halt_pulse |=> !halt_pulse);

  a_r6_single_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_chain |-> (!rd_data[4] && !irq));

  a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rd_data[4] && ovf_irq_en));
endmodule

bind dma_chan_ctl dma_chan_ctl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .mode_chain (mode_chain),
  .xfer_end   (xfer_end),
  .xfer_busy  (xfer_busy),
  .ovf_irq_en (ovf_irq_en),
  .chan_en    (chan_en),
  .halt_pulse (halt_pulse),
  .irq        (irq)
);

// File: tb/dma_chan_ctl_test.sv
module dma_chan_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       mode_chain = 1'b0;
  logic       frame_done = 1'b0;
  logic       xfer_end = 1'b0;
  logic       xfer_busy = 1'b0;
  logic       ovf_irq_en = 1'b0;
  logic       chan_en;
  logic       halt_pulse;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  logic m_en  = 1'b0;
  int   m_cnt = 0;
  logic m_ovf = 1'b0;

  always #10 clk = ~clk;

  dma_chan_ctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mode_chain(mode_chain), .frame_done(frame_done),
    .xfer_end(xfer_end), .xfer_busy(xfer_busy), .ovf_irq_en(ovf_irq_en),
    .chan_en(chan_en), .halt_pulse(halt_pulse), .irq(irq)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic halt_e);
    logic [7:0] rd_e;
    rd_e = {3'b000, mode_chain & m_ovf, 2'b00, m_en, 1'b1};
    chk(tag, "chan_en", int'(chan_en), int'(m_en));
    chk(tag, "halt_pulse", int'(halt_pulse), int'(halt_e));
    chk(tag, "rd_data", int'(rd_data), int'(rd_e));
    chk(tag, "irq", int'(irq), int'(mode_chain & m_ovf & ovf_irq_en));
  endtask

  // one clock: drive, update the model at the edge, check after it
  task automatic cyc(input logic wr, input logic [7:0] d, input logic fd,
                     input logic xe, input logic busy, input string tag);
    logic halt_e;
    logic wrap;
    wr_en = wr; wr_data = d; frame_done = fd; xfer_end = xe; xfer_busy = busy;
    @(posedge clk);
    halt_e = wr && !d[0] && !d[1] && busy && m_en;
    wrap   = mode_chain && fd && (m_cnt == 15);
    if (mode_chain && fd) m_cnt = (m_cnt == 15) ? 0 : m_cnt + 1;
    if (xe) m_en = 1'b0;
    else if (wr && !d[0]) m_en = d[1];
    if (wrap) m_ovf = 1'b1;
    else if (wr && d[4]) m_ovf = 1'b0;
    #2;
    wr_en = 1'b0; wr_data = 8'h00; frame_done = 1'b0; xfer_end = 1'b0; xfer_busy = 1'b0;
    check_all(tag, halt_e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    #5;
    chk("R10", "rd_data in reset", int'(rd_data), 8'h01);
    chk("R10", "chan_en in reset", int'(chan_en), 0);
    chk("R10", "halt in reset", int'(halt_pulse), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check_all("R10", 1'b0);

    // R1 R2: all write values from both enable states, single-block mode
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 256; d++) begin
        cyc(1'b1, (s != 0) ? 8'h02 : 8'h00, 1'b0, 1'b0, 1'b0, "R1");
        cyc(1'b1, 8'(d), 1'b0, 1'b0, 1'b0, "R1 R2");
        cyc(1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, "R1 no write");
      end
    end

    // R3: end strobe clears, and beats a same-cycle guarded write of 1
    cyc(1'b1, 8'h02, 1'b0, 1'b0, 1'b0, "R3");
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R3 end");
    cyc(1'b1, 8'h02, 1'b0, 1'b0, 1'b0, "R3");
    cyc(1'b1, 8'h02, 1'b0, 1'b1, 1'b0, "R3 end vs write");

    // R4: halt only for a guarded clear of a set enable while busy
    for (int busy = 0; busy < 2; busy++) begin
      for (int st = 0; st < 2; st++) begin
        for (int d = 0; d < 4; d++) begin
          cyc(1'b1, (st != 0) ? 8'h02 : 8'h00, 1'b0, 1'b0, 1'b0, "R4 setup");
          cyc(1'b1, 8'(d), 1'b0, 1'b0, busy[0], "R4 halt");
          cyc(1'b0, 8'h00, 1'b0, 1'b0, busy[0], "R4 one cycle");
        end
      end
    end

    // R5 R9: chained counting with the interrupt enable on and off
    mode_chain = 1'b1;
    ovf_irq_en = 1'b1;
    #1;
    for (int k = 0; k < 16; k++) cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R5 R9 count");
    ovf_irq_en = 1'b0;
    #1;
    check_all("R9 ie off", 1'b0);
    ovf_irq_en = 1'b1;
    #1;
    // R7: write 0 to bit 4 keeps the flag, write 1 clears it (guard bit set)
    cyc(1'b1, 8'hEF, 1'b0, 1'b0, 1'b0, "R7 keep");
    cyc(1'b1, 8'h11, 1'b0, 1'b0, 1'b0, "R7 clear");
    // R5: spaced frames, second round
    for (int k = 0; k < 32; k++) cyc(1'b0, 8'h00, k[0], 1'b0, 1'b0, "R5 spaced");
    cyc(1'b1, 8'h10, 1'b0, 1'b0, 1'b0, "R7 clear");
    // R8: clear on the wrapping frame
    for (int k = 0; k < 15; k++) cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R8 lead");
    cyc(1'b1, 8'h10, 1'b1, 1'b0, 1'b0, "R8 set wins");
    chk("R8", "flag after collision", int'(rd_data[4]), 1);
    cyc(1'b1, 8'h10, 1'b0, 1'b0, 1'b0, "R7 clear");

    // R6: single-block frames ignored, count resumes in chained mode
    for (int k = 0; k < 7; k++) cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R6 pre");
    mode_chain = 1'b0;
    #1;
    for (int k = 0; k < 40; k++) cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R6 single");
    mode_chain = 1'b1;
    #1;
    for (int k = 0; k < 9; k++) cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R6 R5 resume");
    chk("R6", "overflow after 16 chained frames", int'(rd_data[4]), 1);
    mode_chain = 1'b0;
    #1;
    check_all("R6 hidden", 1'b0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule